// File: doc/BRIEF.md
# Parallel Annealing Spin Update Engine

This block carries out the per-iteration spin update of a parallel annealing solver for Ising-form optimisation problems. Each of N lanes holds a signed fixed-point proxy value and a momentum value. The binary spin of a lane is the sign of its proxy. A coupling unit outside the block multiplies the current spin vector by the coupling matrix and returns one result per lane over a valid/ready handshake. On each accepted result, every lane updates at once. It forms a gradient from the coupling result, an optional local field and a confinement term weighted by a decaying schedule value λ. It then applies momentum and a step to the proxy, and clips both values to the unit range.

A run begins with a start pulse. The pulse loads the initial proxies from a port, clears momentum, and computes the schedule decrement once with a serial divider. The engine then performs the programmed number of iterations. λ falls linearly from its start value to zero over those iterations. When the last iteration completes, a one-cycle done pulse marks the final spin vector as valid. The matrix product, energy evaluation and problem mapping are handled elsewhere.

Proxy, momentum, β and η are 16-bit values with 13 fraction bits, so 1.0 is 8192. λ, coupling results and local fields are 20-bit values with the same scale. Every product is rounded to nearest with ties toward +∞. In the notation below, rnd(p) = floor((p + 4096) / 8192), and clip(v) limits v to [−8192, 8192].

Top module: `pa_spin_engine`

## Requirements
- R1: Bit i of `spin_o` is 1 when lane i's proxy (`proxy_o[i*16 +: 16]`) is zero or positive, and 0 when it is negative.
- R2: A start pulse while the engine is idle loads every proxy from `init_x_i` and clears every momentum. A start pulse while busy has no effect.
- R3: With T = `iters_i` > 0 and λ0 = `lam0_i`, the λ used in iteration k (k = 0 to T−1) is λ0 − floor(k·λ0/T), and `lambda_o` reads 0 after the T-th update.
- R4: The gradient of lane i is g = c_i + h_i + rnd(λ·x_i), saturated to the signed 20-bit range. Here c_i is `cpl_data_i[i*20 +: 20]` and h_i is `field_i[i*20 +: 20]`.
- R5: The momentum update is m ← clip(rnd(β·m) + rnd((8192−β)·g)).
- R6: The proxy update is x ← clip(x − rnd(η·m)), using the new m. After any update, both x and m lie in [−8192, 8192].
- R7: All N lanes update in the same cycle, from a single accepted coupling vector.
- R8: While `cpl_ready_o` is high and `cpl_valid_i` is low, the proxies and `lambda_o` hold their values.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the T-th handshake. `busy_o` drops in the following cycle, and `cpl_ready_o` stays low from the done pulse onward.
- R10: With `iters_i` = 0, the engine raises `done_o` without asserting `cpl_ready_o`.
- R11: After reset the engine is idle, every proxy is 0, every spin bit is 1, and `lambda_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| iters_i | input | 16 | Total number of iterations T |
| lam0_i | input | 20 | Start value of λ, unsigned, 13 fraction bits |
| beta_i | input | 16 | Momentum constant β, unsigned, 13 fraction bits |
| eta_i | input | 16 | Step size η, unsigned, 13 fraction bits |
| init_x_i | input | 64 | Initial proxies, 16 bits per lane |
| field_i | input | 80 | Local field per lane, 20 bits signed |
| cpl_valid_i | input | 1 | Coupling result valid |
| cpl_data_i | input | 80 | Coupling result per lane, 20 bits signed |
| cpl_ready_o | output | 1 | Engine waits for a coupling result |
| spin_o | output | 4 | Spin vector, 1 means +1 |
| proxy_o | output | 64 | Current proxies, 16 bits per lane |
| lambda_o | output | 20 | Current schedule value λ |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Several properties are checked on every cycle. The proxies stay frozen and λ stays constant while the engine waits on a stalled coupling unit. λ never rises across an accepted update, and every proxy lies within the unit range right after an update. The done pulse lasts a single cycle, ready only appears while busy, and an idle start always makes the engine busy. Other behaviour can only be confirmed by the directed scenarios, which compare each lane against a fixed-point model of the requirements. These include the exact arithmetic of gradient, momentum and proxy, and the exact λ sequence including its remainder spreading. They also cover a start pulse ignored mid-run, the zero-iteration run and the sign of a zero proxy.

// File: rtl/pa_pkg.sv
package pa_pkg;
   localparam int EXT = 48;
   typedef logic signed [EXT-1:0] ext_t;
   typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_RUN, ST_DONE} st_e;

   // round to nearest, ties toward +infinity, then drop f fraction bits
   function automatic ext_t rnd_shr(ext_t v, int f);
      return (v + (ext_t'(1) <<< (f - 1))) >>> f;
   endfunction

   // saturate to a w-bit two's-complement range
   function automatic ext_t sat_w(ext_t v, int w);
      ext_t hi, lo;
      hi = (ext_t'(1) <<< (w - 1)) - ext_t'(1);
      lo = -(ext_t'(1) <<< (w - 1));
      if (v > hi)      return hi;
      else if (v < lo) return lo;
      else             return v;
   endfunction

   // symmetric clip to [-lim, +lim]
   function automatic ext_t clamp_sym(ext_t v, ext_t lim);
      if (v > lim)       return lim;
      else if (v < -lim) return -lim;
      else               return v;
   endfunction
endpackage

// File: rtl/pa_lane.sv
module pa_lane
   import pa_pkg::*;
#(
   parameter int W  = 16,
   parameter int F  = 13,
   parameter int GW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          upd_i,
   input  logic [W-1:0]  init_i,
   input  logic [GW-1:0] cpl_i,
   input  logic [GW-1:0] field_i,
   input  logic [GW-1:0] lam_i,
   input  logic [W-1:0]  beta_i,
   input  logic [W-1:0]  eta_i,
   output logic [W-1:0]  x_o,
   output logic          spin_o
);
   localparam ext_t ONE = ext_t'(1) <<< F;

   logic signed [W-1:0] x_q, m_q;
   ext_t x_e, m_e, lam_e, cpl_e, fld_e, beta_e, omb_e, eta_e;
   ext_t g_e, m_nx, x_nx;
   logic unused_hi;

   always_comb begin
      x_e    = ext_t'(x_q);
      m_e    = ext_t'(m_q);
      lam_e  = ext_t'({1'b0, lam_i});
      cpl_e  = ext_t'($signed(cpl_i));
      fld_e  = ext_t'($signed(field_i));
      beta_e = ext_t'({1'b0, beta_i});
      eta_e  = ext_t'({1'b0, eta_i});
      omb_e  = ONE - beta_e;
      g_e    = sat_w(cpl_e + fld_e + rnd_shr(lam_e * x_e, F), GW);
      m_nx   = clamp_sym(rnd_shr(beta_e * m_e, F) + rnd_shr(omb_e * g_e, F), ONE);
      x_nx   = clamp_sym(x_e - rnd_shr(eta_e * m_nx, F), ONE);
   end

   assign unused_hi = ^{x_nx[EXT-1:W], m_nx[EXT-1:W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         m_q <= '0;
      end else if (load_i) begin
         x_q <= $signed(init_i);
         m_q <= '0;
      end else if (upd_i) begin
         x_q <= x_nx[W-1:0];
         m_q <= m_nx[W-1:0];
      end
   end

   assign x_o    = x_q;
   assign spin_o = ~x_q[W-1];
endmodule

// File: rtl/pa_sched.sv
module pa_sched #(
   parameter int GW = 20,
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [GW-1:0] lam0_i,
   input  logic [TW-1:0] total_i,
   input  logic          step_i,
   output logic          rdy_o,
   output logic [GW-1:0] lam_o
);
   localparam int CW = $clog2(GW + 1);

   logic [GW-1:0] quo_q, lam_q, lam_nx;
   logic [TW-1:0] rem_q, acc_q, tot_q;
   logic [CW-1:0] cnt_q;
   logic          div_act_q;
   logic [TW:0]   tmp, dif, acc_sum, acc_dif;
   logic          ge, carry, unused_top;

   always_comb begin
      tmp     = {rem_q, quo_q[GW-1]};
      dif     = tmp - {1'b0, tot_q};
      ge      = (tmp >= {1'b0, tot_q});
      acc_sum = {1'b0, acc_q} + {1'b0, rem_q};
      acc_dif = acc_sum - {1'b0, tot_q};
      carry   = (acc_sum >= {1'b0, tot_q});
      lam_nx  = lam_q - quo_q - {{(GW-1){1'b0}}, carry};
   end

   assign unused_top = dif[TW] ^ acc_dif[TW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q     <= '0;
         rem_q     <= '0;
         cnt_q     <= '0;
         div_act_q <= 1'b0;
         lam_q     <= '0;
         acc_q     <= '0;
         tot_q     <= '0;
      end else if (start_i) begin
         quo_q     <= lam0_i;
         rem_q     <= '0;
         cnt_q     <= '0;
         div_act_q <= 1'b1;
         lam_q     <= lam0_i;
         acc_q     <= '0;
         tot_q     <= total_i;
      end else if (div_act_q) begin
         quo_q <= {quo_q[GW-2:0], ge};
         rem_q <= ge ? dif[TW-1:0] : tmp[TW-1:0];
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(GW - 1)) div_act_q <= 1'b0;
      end else if (step_i) begin
         lam_q <= lam_nx;
         acc_q <= carry ? acc_dif[TW-1:0] : acc_sum[TW-1:0];
      end
   end

   assign rdy_o = ~div_act_q;
   assign lam_o = lam_q;
endmodule

// File: rtl/pa_spin_engine.sv
module pa_spin_engine
   import pa_pkg::*;
#(
   parameter int N         = 4,
   parameter int W         = 16,
   parameter int F         = 13,
   parameter int GW        = 20,
   parameter int TW        = 16,
   parameter bit USE_FIELD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [TW-1:0]   iters_i,
   input  logic [GW-1:0]   lam0_i,
   input  logic [W-1:0]    beta_i,
   input  logic [W-1:0]    eta_i,
   input  logic [N*W-1:0]  init_x_i,
   input  logic [N*GW-1:0] field_i,
   input  logic            cpl_valid_i,
   input  logic [N*GW-1:0] cpl_data_i,
   output logic            cpl_ready_o,
   output logic [N-1:0]    spin_o,
   output logic [N*W-1:0]  proxy_o,
   output logic [GW-1:0]   lambda_o,
   output logic            busy_o,
   output logic            done_o
);
   if (W < F + 3) begin : g_chk_w
      $error("W must hold sign, two integer bits and F fraction bits");
   end
   if (GW <= W) begin : g_chk_gw
      $error("GW must exceed W");
   end
   if (GW + W + 4 > EXT) begin : g_chk_ext
      $error("internal width too small for GW and W");
   end
   if (N < 1 || TW < 1) begin : g_chk_n
      $error("N and TW must be positive");
   end

   st_e           st_q, st_nx;
   logic [W-1:0]  beta_q, eta_q;
   logic [TW-1:0] tot_q, it_q;
   logic          start_ok, hs, last_it, sch_rdy;
   logic [GW-1:0] lam;

   assign start_ok = start_i && (st_q == ST_IDLE);
   assign hs       = (st_q == ST_RUN) && cpl_valid_i;
   assign last_it  = (it_q == tot_q - 1'b1);

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         ST_IDLE: if (start_ok) st_nx = ST_DIV;
         ST_DIV:  if (sch_rdy) st_nx = (tot_q == '0) ? ST_DONE : ST_RUN;
         ST_RUN:  if (hs && last_it) st_nx = ST_DONE;
         ST_DONE: st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beta_q <= '0;
         eta_q  <= '0;
         tot_q  <= '0;
         it_q   <= '0;
      end else begin
         st_q <= st_nx;
         if (start_ok) begin
            beta_q <= beta_i;
            eta_q  <= eta_i;
            tot_q  <= iters_i;
            it_q   <= '0;
         end else if (hs) begin
            it_q <= it_q + 1'b1;
         end
      end
   end

   pa_sched #(.GW(GW), .TW(TW)) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_ok),
      .lam0_i  (lam0_i),
      .total_i (iters_i),
      .step_i  (hs),
      .rdy_o   (sch_rdy),
      .lam_o   (lam)
   );

   for (genvar i = 0; i < N; i++) begin : g_lane
      logic [GW-1:0] fld;
      if (USE_FIELD) begin : g_fld
         assign fld = field_i[i*GW +: GW];
      end else begin : g_nofld
         assign fld = '0;
      end

      pa_lane #(.W(W), .F(F), .GW(GW)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (start_ok),
         .upd_i   (hs),
         .init_i  (init_x_i[i*W +: W]),
         .cpl_i   (cpl_data_i[i*GW +: GW]),
         .field_i (fld),
         .lam_i   (lam),
         .beta_i  (beta_q),
         .eta_i   (eta_q),
         .x_o     (proxy_o[i*W +: W]),
         .spin_o  (spin_o[i])
      );
   end

   assign cpl_ready_o = (st_q == ST_RUN);
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = (st_q == ST_DONE);
   assign lambda_o    = lam;
endmodule

// File: rtl/pa_spin_engine_chk.sv
module pa_spin_engine_chk #(
   parameter int N  = 4,
   parameter int W  = 16,
   parameter int F  = 13,
   parameter int GW = 20
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic           cpl_valid_i,
   input logic           cpl_ready_o,
   input logic [N*W-1:0] proxy_o,
   input logic [GW-1:0]  lambda_o,
   input logic           busy_o,
   input logic           done_o
);
   localparam int ONE = 1 << F;

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_ready_o |-> (busy_o && !done_o));

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_ready_o && !cpl_valid_i && !done_o) |=> ($stable(proxy_o) && $stable(lambda_o)));

   p_lambda_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_ready_o && cpl_valid_i) |=> (lambda_o <= $past(lambda_o)));

   p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   for (genvar i = 0; i < N; i++) begin : g_rng
      p_proxy_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (cpl_ready_o && cpl_valid_i) |=>
            (($signed(proxy_o[i*W +: W]) <= ONE) && ($signed(proxy_o[i*W +: W]) >= -ONE)));
   end
endmodule

bind pa_spin_engine pa_spin_engine_chk #(.N(N), .W(W), .F(F), .GW(GW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .cpl_valid_i (cpl_valid_i),
   .cpl_ready_o (cpl_ready_o),
   .proxy_o     (proxy_o),
   .lambda_o    (lambda_o),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/tb_pa_spin_engine.sv
module tb_pa_spin_engine;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int W  = 16;
   localparam int GW = 20;
   localparam int TW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [TW-1:0]   iters_i = '0;
   logic [GW-1:0]   lam0_i = '0;
   logic [W-1:0]    beta_i = '0;
   logic [W-1:0]    eta_i = '0;
   logic [N*W-1:0]  init_x_i = '0;
   logic [N*GW-1:0] field_i = '0;
   logic            cpl_valid_i = 1'b0;
   logic [N*GW-1:0] cpl_data_i = '0;
   logic            cpl_ready_o;
   logic [N-1:0]    spin_o;
   logic [N*W-1:0]  proxy_o;
   logic [GW-1:0]   lambda_o;
   logic            busy_o, done_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   longint xm[N], mm[N], xinit[N], fld[N], cpl[N];

   always #(CLK_PERIOD/2) clk = ~clk;

   pa_spin_engine dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .iters_i(iters_i),
      .lam0_i(lam0_i), .beta_i(beta_i), .eta_i(eta_i), .init_x_i(init_x_i),
      .field_i(field_i), .cpl_valid_i(cpl_valid_i), .cpl_data_i(cpl_data_i),
      .cpl_ready_o(cpl_ready_o), .spin_o(spin_o), .proxy_o(proxy_o),
      .lambda_o(lambda_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint rnd(longint v);
      return (v + 64'sd4096) >>> 13;
   endfunction

   function automatic longint clampv(longint v, longint lim);
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   function automatic longint px(int i);
      return longint'($signed(proxy_o[i*W +: W]));
   endfunction

   // reference update of all lanes from the requirements
   task automatic model_step(longint lam, longint beta, longint eta);
      for (int i = 0; i < N; i++) begin
         longint g;
         g = cpl[i] + fld[i] + rnd(lam * xm[i]);
         if (g > 524287) g = 524287;
         if (g < -524288) g = -524288;
         mm[i] = clampv(rnd(beta * mm[i]) + rnd((8192 - beta) * g), 8192);
         xm[i] = clampv(xm[i] - rnd(eta * mm[i]), 8192);
      end
   endtask

   task automatic check_lanes(string ptag);
      for (int i = 0; i < N; i++) begin
         chk(ptag, px(i), xm[i]);
         chk("R1", longint'(spin_o[i]), (xm[i] >= 0) ? 1 : 0);
      end
   endtask

   task automatic run_case(string ptag, int T, longint lam0, longint beta, longint eta,
                           longint cscale, int seed, int stall_it, int stall_n, bit poke);
      @(negedge clk);
      start_i = 1'b1;
      iters_i = TW'(T);
      lam0_i  = GW'(lam0);
      beta_i  = W'(beta);
      eta_i   = W'(eta);
      for (int i = 0; i < N; i++) begin
         init_x_i[i*W +: W]  = W'(xinit[i]);
         field_i[i*GW +: GW] = GW'(fld[i]);
         xm[i] = xinit[i];
         mm[i] = 0;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk("R2", longint'(busy_o), 1);
      for (int k = 0; k < T; k++) begin
         longint lam_k;
         int w = 0;
         while (!cpl_ready_o && w < 100) begin
            @(negedge clk);
            w++;
         end
         chk("R9", longint'(cpl_ready_o), 1);
         lam_k = lam0 - (longint'(k) * lam0) / longint'(T);
         chk("R3", longint'(lambda_o), lam_k);
         check_lanes(ptag);
         if (k == stall_it) begin
            for (int s = 0; s < stall_n; s++) begin
               if (poke && s == 0) begin
                  start_i = 1'b1;
                  iters_i = TW'(1);
                  init_x_i = '0;
               end
               @(negedge clk);
               start_i = 1'b0;
               chk("R8", longint'(cpl_ready_o), 1);
               chk("R8", longint'(lambda_o), lam_k);
               for (int i = 0; i < N; i++) chk("R2", px(i), xm[i]);
            end
         end
         for (int i = 0; i < N; i++) begin
            cpl[i] = longint'((((k * 37 + i * 53 + seed) % 200) - 100)) * cscale;
            cpl_data_i[i*GW +: GW] = GW'(cpl[i]);
         end
         cpl_valid_i = 1'b1;
         @(negedge clk);
         cpl_valid_i = 1'b0;
         model_step(lam_k, beta, eta);
         chk("R9", longint'(done_o), (k == T - 1) ? 1 : 0);
      end
      chk("R9", longint'(cpl_ready_o), 0);
      check_lanes(ptag);
      chk("R3", longint'(lambda_o), 0);
      @(negedge clk);
      chk("R9", longint'(done_o), 0);
      chk("R9", longint'(busy_o), 0);
   endtask

   task automatic t_reset;
      chk("R11", longint'(busy_o), 0);
      chk("R11", longint'(done_o), 0);
      chk("R11", longint'(cpl_ready_o), 0);
      chk("R11", longint'(spin_o), 15);
      chk("R11", longint'(proxy_o), 0);
      chk("R11", longint'(lambda_o), 0);
   endtask

   task automatic t_basic_stall;
      xinit[0] = 0; xinit[1] = -3000; xinit[2] = 4500; xinit[3] = -1;
      for (int i = 0; i < N; i++) fld[i] = 0;
      run_case("R7", 6, 81920, 8110, 82, 300, 11, 2, 5, 1'b1);
   endtask

   task automatic t_momentum;
      xinit[0] = 2000; xinit[1] = -2000; xinit[2] = 100; xinit[3] = -8000;
      for (int i = 0; i < N; i++) fld[i] = 0;
      run_case("R5", 4, 8192, 4096, 4096, 250, 5, -1, 0, 1'b0);
   endtask

   task automatic t_field;
      xinit[0] = 500; xinit[1] = -500; xinit[2] = 0; xinit[3] = 7000;
      fld[0] = 40000; fld[1] = -40000; fld[2] = 12345; fld[3] = -9000;
      run_case("R4", 4, 16384, 6000, 3000, 200, 77, -1, 0, 1'b0);
   endtask

   task automatic t_clip;
      xinit[0] = 24576; xinit[1] = -24576; xinit[2] = 16000; xinit[3] = -20000;
      fld[0] = 0; fld[1] = 0; fld[2] = 200000; fld[3] = -200000;
      run_case("R6", 5, 16384, 0, 12288, 4000, 3, -1, 0, 1'b0);
      for (int i = 0; i < N; i++) begin
         chk("R6", (px(i) <= 8192 && px(i) >= -8192) ? 1 : 0, 1);
      end
   endtask

   task automatic t_sched;
      xinit[0] = 1000; xinit[1] = -1000; xinit[2] = 2000; xinit[3] = -2000;
      for (int i = 0; i < N; i++) fld[i] = 0;
      run_case("R3", 3, 81920, 8110, 82, 100, 9, -1, 0, 1'b0);
   endtask

   task automatic t_zero_iters;
      bit seen_done = 1'b0;
      bit seen_rdy = 1'b0;
      @(negedge clk);
      start_i = 1'b1;
      iters_i = '0;
      lam0_i  = GW'(81920);
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < 60 && !seen_done; c++) begin
         if (cpl_ready_o) seen_rdy = 1'b1;
         if (done_o) seen_done = 1'b1;
         else @(negedge clk);
      end
      chk("R10", longint'(seen_done), 1);
      chk("R10", longint'(seen_rdy), 0);
      @(negedge clk);
      chk("R10", longint'(busy_o), 0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_stall();
      t_momentum();
      t_field();
      t_clip();
      t_sched();
      t_zero_iters();
      finish_run();
   end
endmodule